// File: doc/BRIEF.md
# Eight-Entry Hardware Semaphore Bank

This block holds eight ownership latches that two agents, a left port and a right port, use to reserve shared resources. The latches sit apart from any data memory. Each port reaches the bank by raising its semaphore select while its memory enable is low. The three lowest address bits pick a latch, and the port then issues a write strobe, a read strobe or both.

A port asks for a latch by writing a zero on data bit 0 and gives it back by writing a one. A read shows a zero to the port that owns the latch and a one to every other observer. While one side holds a latch, a zero written by the other side is kept as a waiting request. That request turns into ownership in the same clock edge that the holder releases the latch, so no third party can take the latch in between. A waiting side can cancel its request by writing a one.

The design is fully synchronous with one clock and a synchronous active-high reset. Read data is registered and holds its value between reads.

Top module: `sem_bank`

## Requirements
- R1: After reset no latch has an owner and no request waits. Both read-data buses show all ones, and every latch reads one on both ports.
- R2: The latch index is address bits [2:0]. All higher address bits have no effect on which latch is written or read.
- R3: A write uses only data bit 0 (0 = request, 1 = release/withdraw). Data bits [7:1] have no effect.
- R4: A request written to a free latch makes the writer its owner. From then on the latch reads 0 on the owner's port and 1 on the other port.
- R5: While a port owns a latch, writes from the other port never change that ownership.
- R6: An owner that writes 1 with no request waiting from the other port frees the latch, and it then reads 1 on both ports.
- R7: If the non-owner wrote 0 while the latch was held, the owner's release passes ownership straight to the non-owner in the same edge.
- R8: A non-owner that writes 1 cancels its waiting request, so a later release by the owner frees the latch.
- R9: When both ports write 0 to the same free latch in one cycle, the left port becomes owner and the right request waits.
- R10: An access takes effect only while select is 1 and memory enable is 0. At any other time writes change nothing and reads leave read data unchanged.
- R11: A read returns the port's view of the latch on bit 0 and ones on bits [7:1]. The value is valid from the clock edge that samples the read strobe. It reflects the state before any write in that same cycle, and it holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left memory enable; must be 0 for a semaphore access |
| l_addr | input | 17 | Left address; bits [2:0] pick the latch |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_wdata | input | 8 | Left write data; bit 0 used |
| l_rdata | output | 8 | Left registered read data |
| r_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right memory enable; must be 0 for a semaphore access |
| r_addr | input | 17 | Right address; bits [2:0] pick the latch |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_wdata | input | 8 | Right write data; bit 0 used |
| r_rdata | output | 8 | Right registered read data |

## Verification
A write changes ownership at the clock edge that samples it. A read strobe in the next cycle is the earliest point at which the change can be seen, and its data appears after that cycle's edge. A read in the same cycle as a write still returns the old view. The bench therefore drives each access at the falling edge and lets one rising edge go by. It samples read data at the following falling edge, so every expected value refers to the state as it stood before that cycle's writes. A row of the stimulus table that holds a read names the value due from that one edge, and the same-cycle case is one of the rows.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } owner_e;

  // Port's view of a latch: 0 when that port owns it, else 1.
  function automatic logic port_view(input owner_e own, input logic is_left);
    if (is_left) return (own != OWN_LEFT);
    else         return (own != OWN_RIGHT);
  endfunction

  // Owner after an owner-side release: waiting or same-cycle request wins.
  function automatic owner_e after_release(input logic other_waits,
                                           input logic other_cancels,
                                           input logic other_asks,
                                           input owner_e other_side);
    if ((other_waits && !other_cancels) || other_asks) return other_side;
    else                                               return OWN_NONE;
  endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int AW   = 17,
  parameter int NSEM = 8,
  localparam int IW  = $clog2(NSEM)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel,
  input  logic            mem_en,
  input  logic [IW-1:0]   idx,
  input  logic            wr,
  input  logic            rd,
  input  logic            wbit,
  output logic [NSEM-1:0] req_vec,
  output logic [NSEM-1:0] rel_vec,
  output logic            rd_ok
);

  logic access_ok;
  assign access_ok = sel && !mem_en;
  assign rd_ok     = access_ok && rd;

  for (genvar i = 0; i < NSEM; i++) begin : g_dec
    logic hit;
    assign hit        = access_ok && wr && (idx == IW'(i));
    assign req_vec[i] = hit && !wbit;
    assign rel_vec[i] = hit && wbit;
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_vec | rel_vec));

  p_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !(sel && !mem_en) |-> ((req_vec == '0) && (rel_vec == '0) && !rd_ok));

endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_bank_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_l,
  input  logic   rel_l,
  input  logic   req_r,
  input  logic   rel_r,
  output owner_e owner
);

  owner_e own_q, own_n;
  logic   wait_l_q, wait_r_q, wait_l_n, wait_r_n;

  always_comb begin
    own_n    = own_q;
    wait_l_n = wait_l_q;
    wait_r_n = wait_r_q;
    unique case (own_q)
      OWN_NONE: begin
        wait_l_n = 1'b0;
        wait_r_n = 1'b0;
        if (req_l) begin
          own_n    = OWN_LEFT;
          wait_r_n = req_r;
        end else if (req_r) begin
          own_n = OWN_RIGHT;
        end
      end
      OWN_LEFT: begin
        wait_l_n = 1'b0;
        if (rel_l) begin
          own_n    = after_release(wait_r_q, rel_r, req_r, OWN_RIGHT);
          wait_r_n = 1'b0;
        end else if (req_r) begin
          wait_r_n = 1'b1;
        end else if (rel_r) begin
          wait_r_n = 1'b0;
        end
      end
      OWN_RIGHT: begin
        wait_r_n = 1'b0;
        if (rel_r) begin
          own_n    = after_release(wait_l_q, rel_l, req_l, OWN_LEFT);
          wait_l_n = 1'b0;
        end else if (req_l) begin
          wait_l_n = 1'b1;
        end else if (rel_l) begin
          wait_l_n = 1'b0;
        end
      end
      default: begin
        own_n    = OWN_NONE;
        wait_l_n = 1'b0;
        wait_r_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q    <= OWN_NONE;
      wait_l_q <= 1'b0;
      wait_r_q <= 1'b0;
    end else begin
      own_q    <= own_n;
      wait_l_q <= wait_l_n;
      wait_r_q <= wait_r_n;
    end
  end

  assign owner = own_q;

  p_tie_left_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (own_q == OWN_NONE && req_l && req_r) |=> (own_q == OWN_LEFT && wait_r_q));

  p_owner_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (own_q == OWN_LEFT && !rel_l) |=> (own_q == OWN_LEFT));

  p_release_free_r6: assert property (@(posedge clk) disable iff (rst)
    (own_q == OWN_LEFT && rel_l && !wait_r_q && !req_r) |=> (own_q == OWN_NONE));

  p_handoff_r7: assert property (@(posedge clk) disable iff (rst)
    (own_q == OWN_RIGHT && rel_r && wait_l_q && !rel_l) |=> (own_q == OWN_LEFT));

  p_withdraw_r8: assert property (@(posedge clk) disable iff (rst)
    (own_q == OWN_LEFT && !rel_l && rel_r) |=> !wait_r_q);

endmodule

// File: rtl/sem_read_port.sv
module sem_read_port
  import sem_bank_pkg::*;
#(
  parameter int NSEM    = 8,
  parameter int DW      = 8,
  parameter bit IS_LEFT = 1'b1,
  localparam int IW     = $clog2(NSEM)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_ok,
  input  logic [IW-1:0]   idx,
  input  owner_e          owners [NSEM],
  output logic [DW-1:0]   rdata
);

  logic [DW-1:0] rdata_q;
  logic          view;

  assign view = port_view(owners[idx], IS_LEFT);

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '1;
    else if (rd_ok) rdata_q <= {{(DW-1){1'b1}}, view};
  end

  assign rdata = rdata_q;

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_ok |=> $stable(rdata_q));

  p_rd_fill_r11: assert property (@(posedge clk) disable iff (rst)
    $countones(rdata_q) >= DW - 1);

endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_bank_pkg::*;
#(
  parameter int AW   = 17,
  parameter int DW   = 8,
  parameter int NSEM = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_sel,
  input  logic          l_mem_en,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wr,
  input  logic          l_rd,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_sel,
  input  logic          r_mem_en,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wr,
  input  logic          r_rd,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);

  localparam int IW = $clog2(NSEM);

  logic [NSEM-1:0] l_req, l_rel, r_req, r_rel;
  logic            l_rd_ok, r_rd_ok;
  owner_e          owners [NSEM];

  logic unused_upper;
  assign unused_upper = ^{l_addr[AW-1:IW], r_addr[AW-1:IW],
                          l_wdata[DW-1:1], r_wdata[DW-1:1]};

  sem_port_decode #(.AW(AW), .NSEM(NSEM)) u_dec_l (
    .clk(clk), .rst(rst), .sel(l_sel), .mem_en(l_mem_en),
    .idx(l_addr[IW-1:0]), .wr(l_wr), .rd(l_rd), .wbit(l_wdata[0]),
    .req_vec(l_req), .rel_vec(l_rel), .rd_ok(l_rd_ok)
  );

  sem_port_decode #(.AW(AW), .NSEM(NSEM)) u_dec_r (
    .clk(clk), .rst(rst), .sel(r_sel), .mem_en(r_mem_en),
    .idx(r_addr[IW-1:0]), .wr(r_wr), .rd(r_rd), .wbit(r_wdata[0]),
    .req_vec(r_req), .rel_vec(r_rel), .rd_ok(r_rd_ok)
  );

  for (genvar i = 0; i < NSEM; i++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst(rst),
      .req_l(l_req[i]), .rel_l(l_rel[i]),
      .req_r(r_req[i]), .rel_r(r_rel[i]),
      .owner(owners[i])
    );
  end

  sem_read_port #(.NSEM(NSEM), .DW(DW), .IS_LEFT(1'b1)) u_rd_l (
    .clk(clk), .rst(rst), .rd_ok(l_rd_ok), .idx(l_addr[IW-1:0]),
    .owners(owners), .rdata(l_rdata)
  );

  sem_read_port #(.NSEM(NSEM), .DW(DW), .IS_LEFT(1'b0)) u_rd_r (
    .clk(clk), .rst(rst), .rd_ok(r_rd_ok), .idx(r_addr[IW-1:0]),
    .owners(owners), .rdata(r_rdata)
  );

endmodule

// File: tb/sem_bank_tb_top.sv
`timescale 1ns/100ps
module sem_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        l_sel = 0, l_mem_en = 0, l_wr = 0, l_rd = 0;
  logic        r_sel = 0, r_mem_en = 0, r_wr = 0, r_rd = 0;
  logic [16:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wdata = '0, r_wdata = '0;
  logic [7:0]  l_rdata, r_rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sem_bank dut_i (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_mem_en(l_mem_en), .l_addr(l_addr), .l_wr(l_wr),
    .l_rd(l_rd), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_mem_en(r_mem_en), .r_addr(r_addr), .r_wr(r_wr),
    .r_rd(r_rd), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  // ops: 0 idle, 1 write zero, 2 write one, 3 read
  // row: {l_op[11:10], l_idx[9:7], r_op[6:5], r_idx[4:2], exp_l[1], exp_r[0]}
  localparam int NV = 21;
  localparam logic [11:0] TBL [NV] = '{
    {2'd1,3'd2,2'd0,3'd0,1'b0,1'b0}, // R4 left asks for latch 2
    {2'd3,3'd2,2'd3,3'd2,1'b0,1'b1}, // R4 views
    {2'd0,3'd0,2'd1,3'd2,1'b0,1'b0}, // R5 right asks while left holds
    {2'd3,3'd2,2'd3,3'd2,1'b0,1'b1}, // R5 unchanged
    {2'd2,3'd2,2'd0,3'd0,1'b0,1'b0}, // R7 left releases
    {2'd3,3'd2,2'd3,3'd2,1'b1,1'b0}, // R7 right owns
    {2'd0,3'd0,2'd2,3'd2,1'b0,1'b0}, // R6 right releases
    {2'd3,3'd2,2'd3,3'd2,1'b1,1'b1}, // R6 free
    {2'd1,3'd5,2'd1,3'd5,1'b0,1'b0}, // R9 tie
    {2'd3,3'd5,2'd3,3'd5,1'b0,1'b1}, // R9 left wins
    {2'd0,3'd0,2'd2,3'd5,1'b0,1'b0}, // R8 right withdraws
    {2'd3,3'd5,2'd3,3'd5,1'b0,1'b1}, // R5 one from non-owner does not free
    {2'd2,3'd5,2'd0,3'd0,1'b0,1'b0}, // R8 left releases
    {2'd3,3'd5,2'd3,3'd5,1'b1,1'b1}, // R8 free, no handoff
    {2'd0,3'd0,2'd1,3'd7,1'b0,1'b0}, // R4 right takes 7
    {2'd1,3'd7,2'd0,3'd0,1'b0,1'b0}, // R5 left waits
    {2'd2,3'd7,2'd0,3'd0,1'b0,1'b0}, // R8 left withdraws
    {2'd0,3'd0,2'd2,3'd7,1'b0,1'b0}, // R6 right releases
    {2'd3,3'd7,2'd3,3'd7,1'b1,1'b1}, // R8 free
    {2'd3,3'd0,2'd1,3'd0,1'b1,1'b0}, // R11 read sees state before write
    {2'd3,3'd0,2'd3,3'd0,1'b1,1'b0}  // R4 right owns 0
  };

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idle_ports();
    l_sel = 0; l_mem_en = 0; l_wr = 0; l_rd = 0; l_wdata = '0;
    r_sel = 0; r_mem_en = 0; r_wr = 0; r_rd = 0; r_wdata = '0;
  endtask

  task automatic set_left(input logic [1:0] op, input logic [16:0] a);
    l_sel = (op != 0); l_mem_en = 0; l_addr = a;
    l_wr = (op == 1) || (op == 2); l_rd = (op == 3);
    l_wdata = (op == 2) ? 8'h01 : 8'h00;
  endtask

  task automatic set_right(input logic [1:0] op, input logic [16:0] a);
    r_sel = (op != 0); r_mem_en = 0; r_addr = a;
    r_wr = (op == 1) || (op == 2); r_rd = (op == 3);
    r_wdata = (op == 2) ? 8'h01 : 8'h00;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle_ports();
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state of read buses
    check("R1 l_rdata after reset", l_rdata, 8'hFF);
    check("R1 r_rdata after reset", r_rdata, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      set_left(2'd3, 17'(i)); set_right(2'd3, 17'(i)); tick();
      check("R1 left view free", l_rdata, 8'hFF);
      check("R1 right view free", r_rdata, 8'hFF);
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [11:0] row;
      row = TBL[v];
      set_left(row[11:10], {14'd0, row[9:7]});
      set_right(row[6:5], {14'd0, row[4:2]});
      tick();
      if (row[11:10] == 2'd3)
        check($sformatf("table row %0d left R4 R5 R6 R7 R8 R9 R11", v), l_rdata, {7'h7F, row[1]});
      if (row[6:5] == 2'd3)
        check($sformatf("table row %0d right R4 R5 R6 R7 R8 R9 R11", v), r_rdata, {7'h7F, row[0]});
    end

    // R2 upper address bits ignored
    set_left(2'd1, 17'h12343); tick();
    set_left(2'd3, 17'h0AAAB); set_right(2'd3, 17'h1FFFB); tick();
    check("R2 left owns via aliased address", l_rdata, 8'hFE);
    check("R2 right sees held", r_rdata, 8'hFF);
    set_left(2'd2, 17'h0FFF3); tick();
    set_right(2'd3, 17'h00003); tick();
    check("R2 released via aliased address", r_rdata, 8'hFF);

    // R3 only bit 0 of write data matters
    set_left(2'd1, 17'd4); l_wdata = 8'hFE; tick();
    set_left(2'd3, 17'd4); tick();
    check("R3 FE acts as request", l_rdata, 8'hFE);
    set_left(2'd2, 17'd4); l_wdata = 8'h01; tick();
    set_right(2'd2, 17'd4); r_wdata = 8'h00; r_wdata[0] = 1'b1; tick();
    set_left(2'd3, 17'd4); set_right(2'd1, 17'd4); r_wdata = 8'hF0; tick();
    check("R3 release by 01", l_rdata, 8'hFF);
    set_right(2'd3, 17'd4); tick();
    check("R3 F0 acts as request", r_rdata, 8'hFE);
    set_right(2'd2, 17'd4); r_wdata = 8'hFF; tick();

    // R10 access gating
    set_left(2'd1, 17'd6); l_mem_en = 1; tick();
    set_left(2'd1, 17'd6); l_sel = 0; tick();
    set_right(2'd1, 17'd6); tick();
    set_left(2'd3, 17'd6); set_right(2'd3, 17'd6); tick();
    check("R10 gated left writes ignored (left view)", l_rdata, 8'hFF);
    check("R10 right got latch", r_rdata, 8'hFE);
    set_right(2'd3, 17'd1); r_mem_en = 1; tick();
    check("R10 gated read leaves rdata", r_rdata, 8'hFE);
    set_right(2'd3, 17'd1); r_sel = 0; tick();
    check("R10 deselected read leaves rdata", r_rdata, 8'hFE);

    // R11 hold with no read
    tick(); tick();
    check("R11 left hold", l_rdata, 8'hFF);
    check("R11 right hold", r_rdata, 8'hFE);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule